// File: doc/BRIEF.md
# DRAM Page and Read-Modify-Write Cycle Controller

This block runs an external 64K x 4 DRAM for an internal client. It takes one request at a time over a valid/ready handshake and turns it into a complete strobe sequence on an 8-bit multiplexed address bus: active-low RAS, CAS, WE and OE, a 4-bit write-data bus with its own enable, and a 4-bit read-data input. Every edge is placed on a whole master-clock period, and all strobes, the address and the data-bus enable come straight from registers.

Three cycle types are offered. A page read opens one row and fetches up to `MAX_BEATS` columns from a list supplied with the request. A page write stores up to `MAX_BEATS` nibbles to such a list. A read-modify-write opens one row and one column, reads the stored nibble, combines it with an operand (XOR, OR, AND or plain replace), and writes the result back, all under one RAS and one CAS low period. This suits pixel updates that XOR into a frame store. Read data, including the old value seen by a read-modify-write, comes back on `rd_data` with a one-cycle `rd_valid` pulse.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: The row sits on `dram_addr` in the cycle before RAS falls and in the first RAS-low cycle. Each column sits on `dram_addr` from the cycle before its CAS fall through its CAS-low cycle. Column k of a page burst is `req_cols[8k+7:8k]`, and a read-modify-write uses column 0. `dram_addr` reads 0 while no row is being opened or held.
- R2: RAS stays low for at least 3 cycles and stays high for at least 2 cycles between cycles. When a request is already waiting at the first precharge cycle, RAS is high for exactly 2 cycles.
- R3: In a page cycle, CAS first falls 2 cycles after RAS falls and is low for exactly 1 cycle. Later columns follow every 2 cycles. RAS rises in the cycle after the last CAS-low cycle. CAS is never low while RAS is high.
- R4: During a page read, WE is high and OE is low while RAS is low. `dram_dq_i` is sampled at the end of each CAS-low cycle and is returned on `rd_data` with `rd_valid` high in the following cycle, in column-list order.
- R5: During a page write, OE is high and WE is low while RAS is low. The bus is driven from the second RAS-low cycle through the last CAS-low cycle. Beat k, `req_wdata[4k+3:4k]`, is driven in the cycle before and the cycle of the k-th CAS-low cycle.
- R6: A read-modify-write holds RAS low for 7 cycles and CAS low for 5 cycles, starting 2 cycles after RAS falls. OE is low only in the first 2 CAS-low cycles. WE is low for 1 cycle, 4 cycles after CAS falls. With back-to-back requests the cycle repeats every 9 clocks.
- R7: A read-modify-write samples the old nibble at the end of the second CAS-low cycle and returns it with `rd_valid` in the next cycle. It drives, in the fourth and fifth CAS-low cycles, the old nibble combined with `req_wdata[3:0]` by `req_op`: 0 XOR, 1 OR, 2 AND, 3 replace.
- R8: `dram_dq_oe` is high only during write phases and never while OE is low.
- R9: `req_ready` is high in idle and in the first precharge cycle after a cycle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_kind` codes: 0 page read, 1 page write, 2 read-modify-write, 3 page read. A `req_beats` of 0 means 1 beat, and values above `MAX_BEATS` are limited to `MAX_BEATS`.
- R10: During reset all four strobes are high and `dram_dq_oe`, `rd_valid` and `req_ready` are low. After reset is released, `req_ready` stays low for `INIT_CYC` cycles and then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Cycle type code |
| req_op | input | 2 | Modify operation for read-modify-write |
| req_row | input | A_W | Row address |
| req_cols | input | MAX_BEATS*A_W | Column list, entry k in bits [A_W*k +: A_W] |
| req_beats | input | $clog2(MAX_BEATS+1) | Number of columns in a page burst |
| req_wdata | input | MAX_BEATS*DQ_W | Write beats, or operand in the low nibble |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DQ_W | Returned read data |
| dram_addr | output | A_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DQ_W | Write data to the bus |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DQ_W | Data read from the bus |

## Verification
Two things can happen in the same cycle: the last read nibble of a page read returns on `rd_valid`, and the next request is taken in the first precharge cycle. The bench provokes this by raising the following request while a burst is still running, so the handshake completes in the precharge cycle that carries the final data beat. A per-cycle expected trace is built from the requirements when a request is taken. Strobes, address, bus enable, write data, read return and `req_ready` are compared against it on every clock. The same overlap is used for read-modify-write requests issued back to back, which must show the 9-cycle period and a 2-cycle RAS-high gap.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_INIT = 3'd0,
        ST_IDLE = 3'd1,
        ST_ROW  = 3'd2,
        ST_ACT  = 3'd3,
        ST_PRE  = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        K_RD  = 2'd0,
        K_WR  = 2'd1,
        K_RMW = 2'd2
    } cyc_kind_e;

    localparam logic [1:0] OP_XOR = 2'd0;
    localparam logic [1:0] OP_OR  = 2'd1;
    localparam logic [1:0] OP_AND = 2'd2;
    localparam logic [1:0] OP_SET = 2'd3;

    // read-modify-write step positions, counted from the first RAS-low cycle
    localparam int RMW_CAS_AT = 2;
    localparam int RMW_CAP_AT = 3;
    localparam int RMW_DRV_AT = 5;
    localparam int RMW_WE_AT  = 6;
    localparam int RMW_LAST   = 6;

endpackage

// File: rtl/dcc_modify.sv
module dcc_modify #(
    parameter int DQ_W = 4
) (
    input  logic [DQ_W-1:0] old_val,
    input  logic [DQ_W-1:0] operand,
    input  logic [1:0]      op,
    output logic [DQ_W-1:0] new_val
);
    import dcc_pkg::*;

    always_comb begin
        case (op)
            OP_XOR:  new_val = old_val ^ operand;
            OP_OR:   new_val = old_val | operand;
            OP_AND:  new_val = old_val & operand;
            default: new_val = operand;
        endcase
    end

endmodule

// File: rtl/dcc_seq.sv
module dcc_seq #(
    parameter int A_W      = 8,
    parameter int MAXB     = 4,
    parameter int INIT_CYC = 2,
    localparam int BEAT_W  = (MAXB > 1) ? $clog2(MAXB) : 1,
    localparam int BCNT_W  = $clog2(MAXB + 1),
    localparam int STEP_W  = $clog2(2 * MAXB + 8),
    localparam int INIT_W  = $clog2(INIT_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [A_W-1:0]        req_row,
    input  logic [MAXB*A_W-1:0]   req_cols,
    input  logic [BCNT_W-1:0]     req_beats,
    output logic                  req_ready,
    output logic                  accept,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic                  oe_n,
    output logic [A_W-1:0]        addr,
    output logic                  dq_oe,
    output logic [BEAT_W-1:0]     beat,
    output logic                  rmw_sel,
    output logic                  cap_rd,
    output logic                  cap_rmw
);
    import dcc_pkg::*;

    typedef struct packed {
        seq_st_e             st;
        logic [INIT_W-1:0]   cnt;
        logic [STEP_W-1:0]   step;
        logic [STEP_W-1:0]   last;
        cyc_kind_e           kind;
        logic [A_W-1:0]      row;
        logic [MAXB*A_W-1:0] cols;
        logic                ras;
        logic                cas;
        logic                we;
        logic                oe;
        logic [A_W-1:0]      addr;
        logic                dqoe;
        logic [BEAT_W-1:0]   beat;
        logic                rmw;
    } seq_t;

    seq_t q, n;
    logic [BCNT_W-1:0] beats_eff;
    logic [BEAT_W-1:0] kb;
    logic              kind_rmw;

    assign req_ready = (q.st == ST_IDLE) || (q.st == ST_PRE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        n  = q;
        kb = '0;
        beats_eff = req_beats;
        if (req_beats == '0)
            beats_eff = BCNT_W'(1);
        else if (req_beats > BCNT_W'(MAXB))
            beats_eff = BCNT_W'(MAXB);

        // state advance
        case (q.st)
            ST_INIT: begin
                if (q.cnt == INIT_W'(INIT_CYC - 1))
                    n.st = ST_IDLE;
                else
                    n.cnt = q.cnt + 1'b1;
            end
            ST_IDLE, ST_PRE: begin
                if (req_valid) begin
                    n.st   = ST_ROW;
                    n.row  = req_row;
                    n.cols = req_cols;
                    case (req_kind)
                        2'd1:    n.kind = K_WR;
                        2'd2:    n.kind = K_RMW;
                        default: n.kind = K_RD;
                    endcase
                    n.last = (n.kind == K_RMW) ? STEP_W'(RMW_LAST)
                                               : STEP_W'(2 * beats_eff);
                end else begin
                    n.st = ST_IDLE;
                end
            end
            ST_ROW: begin
                n.st   = ST_ACT;
                n.step = '0;
            end
            ST_ACT: begin
                if (q.step == q.last)
                    n.st = ST_PRE;
                else
                    n.step = q.step + 1'b1;
            end
            default: n.st = ST_IDLE;
        endcase

        // strobes for the coming cycle, decoded from the next state
        n.ras  = 1'b1;
        n.cas  = 1'b1;
        n.we   = 1'b1;
        n.oe   = 1'b1;
        n.addr = '0;
        n.dqoe = 1'b0;
        n.beat = '0;
        n.rmw  = 1'b0;
        if (n.st == ST_ROW)
            n.addr = n.row;
        if (n.st == ST_ACT) begin
            n.ras = 1'b0;
            if (n.kind == K_RMW) begin
                n.rmw  = 1'b1;
                n.addr = (n.step == '0) ? n.row : n.cols[A_W-1:0];
                n.cas  = !(n.step >= STEP_W'(RMW_CAS_AT));
                n.oe   = !((n.step == STEP_W'(RMW_CAS_AT)) ||
                           (n.step == STEP_W'(RMW_CAP_AT)));
                n.we   = !(n.step == STEP_W'(RMW_WE_AT));
                n.dqoe = (n.step == STEP_W'(RMW_DRV_AT)) ||
                         (n.step == STEP_W'(RMW_WE_AT));
            end else begin
                if (n.step != '0)
                    kb = BEAT_W'((n.step - 1'b1) >> 1);
                n.addr = (n.step == '0) ? n.row : n.cols[kb*A_W +: A_W];
                n.cas  = !((n.step >= STEP_W'(2)) && !n.step[0]);
                n.beat = kb;
                if (n.kind == K_WR) begin
                    n.we   = 1'b0;
                    n.dqoe = (n.step != '0);
                end else begin
                    n.oe   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_INIT;
            q.ras <= 1'b1;
            q.cas <= 1'b1;
            q.we  <= 1'b1;
            q.oe  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign ras_n    = q.ras;
    assign cas_n    = q.cas;
    assign we_n     = q.we;
    assign oe_n     = q.oe;
    assign addr     = q.addr;
    assign dq_oe    = q.dqoe;
    assign beat     = q.beat;
    assign rmw_sel  = q.rmw;
    assign kind_rmw = (q.kind == K_RMW);
    assign cap_rd   = (q.st == ST_ACT) && (q.kind == K_RD) &&
                      (q.step >= STEP_W'(2)) && !q.step[0];
    assign cap_rmw  = (q.st == ST_ACT) && kind_rmw &&
                      (q.step == STEP_W'(RMW_CAP_AT));

    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (!$past(ras_n, 2) && !$past(ras_n, 3)))
        else $error("RAS low shorter than 3 cycles"); // R2
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(ras_n, 2))
        else $error("RAS precharge shorter than 2 cycles"); // R2
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n)
        else $error("CAS low while RAS high"); // R3
    AST_PAGE_CAS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !kind_rmw) |=> cas_n)
        else $error("page CAS low longer than 1 cycle"); // R3
    AST_RMW_CAS_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n) && kind_rmw) |-> (!$past(cas_n, 5) && $past(cas_n, 6)))
        else $error("RMW CAS low not 5 cycles"); // R6
    AST_RMW_WE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) && kind_rmw) |-> (!$past(cas_n, 4) && $past(cas_n, 5)))
        else $error("RMW WE not 4 cycles after CAS"); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n)
        else $error("bus driven while OE low"); // R8

endmodule

// File: rtl/dcc_data.sv
module dcc_data #(
    parameter int DQ_W   = 4,
    parameter int MAXB   = 4,
    localparam int BEAT_W = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [MAXB*DQ_W-1:0]   req_wdata,
    input  logic [1:0]             req_op,
    input  logic                   cap_rd,
    input  logic                   cap_rmw,
    input  logic [BEAT_W-1:0]      beat,
    input  logic                   rmw_sel,
    input  logic [DQ_W-1:0]        dq_i,
    output logic [DQ_W-1:0]        dq_o,
    output logic                   rd_valid,
    output logic [DQ_W-1:0]        rd_data
);
    typedef struct packed {
        logic [MAXB*DQ_W-1:0] wdata;
        logic [1:0]           op;
        logic [DQ_W-1:0]      mod;
        logic                 rv;
        logic [DQ_W-1:0]      rd;
    } dat_t;

    dat_t q, n;
    logic [DQ_W-1:0] mod_y;

    dcc_modify #(.DQ_W(DQ_W)) modify_i (
        .old_val (dq_i),
        .operand (q.wdata[DQ_W-1:0]),
        .op      (q.op),
        .new_val (mod_y)
    );

    always_comb begin
        n    = q;
        n.rv = cap_rd || cap_rmw;
        if (accept) begin
            n.wdata = req_wdata;
            n.op    = req_op;
        end
        if (cap_rd || cap_rmw)
            n.rd = dq_i;
        if (cap_rmw)
            n.mod = mod_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= n;
    end

    assign dq_o     = rmw_sel ? q.mod : q.wdata[beat*DQ_W +: DQ_W];
    assign rd_valid = q.rv;
    assign rd_data  = q.rd;

    AST_RV_SINGLE_RMW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rmw_sel) |=> !rd_valid)
        else $error("RMW returned more than one nibble"); // R7

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
    parameter int A_W       = 8,
    parameter int DQ_W      = 4,
    parameter int MAX_BEATS = 4,
    parameter int INIT_CYC  = 2,
    localparam int BCNT_W   = $clog2(MAX_BEATS + 1),
    localparam int BEAT_W   = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_kind,
    input  logic [1:0]                req_op,
    input  logic [A_W-1:0]            req_row,
    input  logic [MAX_BEATS*A_W-1:0]  req_cols,
    input  logic [BCNT_W-1:0]         req_beats,
    input  logic [MAX_BEATS*DQ_W-1:0] req_wdata,
    output logic                      rd_valid,
    output logic [DQ_W-1:0]           rd_data,
    output logic [A_W-1:0]            dram_addr,
    output logic                      dram_ras_n,
    output logic                      dram_cas_n,
    output logic                      dram_we_n,
    output logic                      dram_oe_n,
    output logic [DQ_W-1:0]           dram_dq_o,
    output logic                      dram_dq_oe,
    input  logic [DQ_W-1:0]           dram_dq_i
);
    logic              accept;
    logic [BEAT_W-1:0] beat;
    logic              rmw_sel;
    logic              cap_rd;
    logic              cap_rmw;

    dcc_seq #(
        .A_W      (A_W),
        .MAXB     (MAX_BEATS),
        .INIT_CYC (INIT_CYC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_row   (req_row),
        .req_cols  (req_cols),
        .req_beats (req_beats),
        .req_ready (req_ready),
        .accept    (accept),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .addr      (dram_addr),
        .dq_oe     (dram_dq_oe),
        .beat      (beat),
        .rmw_sel   (rmw_sel),
        .cap_rd    (cap_rd),
        .cap_rmw   (cap_rmw)
    );

    dcc_data #(
        .DQ_W (DQ_W),
        .MAXB (MAX_BEATS)
    ) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .req_op    (req_op),
        .cap_rd    (cap_rd),
        .cap_rmw   (cap_rmw),
        .beat      (beat),
        .rmw_sel   (rmw_sel),
        .dq_i      (dram_dq_i),
        .dq_o      (dram_dq_o),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    AST_WE_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_ras_n)
        else $error("WE low outside a RAS-low period"); // R5

endmodule

// File: tb/dram_cycle_ctrl_tb.sv
module dram_cycle_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_CYC   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_row = '0;
    logic [31:0] req_cols = '0;
    logic [2:0]  req_beats = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  dram_dq_o;
    logic        dram_dq_oe;
    logic [3:0]  dram_dq_i;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_op(req_op), .req_row(req_row), .req_cols(req_cols),
        .req_beats(req_beats), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );

    // memory content as a function of row and column
    function automatic logic [3:0] pat(input logic [7:0] r, input logic [7:0] c);
        return r[3:0] ^ c[7:4] ^ {c[2:0], c[3]};
    endfunction

    function automatic logic [3:0] modf(input logic [3:0] a, input logic [3:0] b,
                                        input logic [1:0] op);
        case (op)
            2'd0:    return a ^ b;
            2'd1:    return a | b;
            2'd2:    return a & b;
            default: return b;
        endcase
    endfunction

    logic [7:0] open_row = '0;
    always @(negedge dram_ras_n) open_row <= dram_addr;
    assign dram_dq_i = pat(open_row, dram_addr);

    typedef struct packed {
        logic       ras, cas, we, oe;
        logic [7:0] addr;
        logic       dqoe;
        logic [3:0] dq;
        logic       rv;
        logic [3:0] rd;
    } exp_t;

    exp_t exq[$];

    function automatic exp_t idle_v();
        exp_t e;
        e = '0;
        e.ras = 1'b1; e.cas = 1'b1; e.we = 1'b1; e.oe = 1'b1;
        return e;
    endfunction

    // expected per-cycle trace of one request, from the ROW cycle to precharge
    function automatic void plan(input logic [1:0] kind_in, input logic [7:0] r,
                                 input logic [31:0] c, input logic [2:0] b,
                                 input logic [15:0] w, input logic [1:0] op);
        exp_t e;
        int   k, nb, last;
        bit   rmw, wr;
        logic [7:0] c0;
        rmw = (kind_in == 2'd2);
        wr  = (kind_in == 2'd1);
        nb  = (b == 0) ? 1 : ((b > 4) ? 4 : int'(b));
        c0  = c[7:0];
        last = rmw ? 6 : 2 * nb;
        e = idle_v(); e.addr = r; exq.push_back(e);
        for (int s = 0; s <= last; s++) begin
            e = idle_v();
            e.ras = 1'b0;
            k = (s >= 1) ? (s - 1) / 2 : 0;
            if (s == 0) e.addr = r;
            else e.addr = rmw ? c0 : c[8*k +: 8];
            if (rmw) begin
                e.cas  = !(s >= 2);
                e.oe   = !(s == 2 || s == 3);
                e.we   = !(s == 6);
                e.dqoe = (s == 5 || s == 6);
                e.dq   = modf(pat(r, c0), w[3:0], op);
                if (s == 4) begin e.rv = 1'b1; e.rd = pat(r, c0); end
            end else begin
                e.cas = !(s >= 2 && (s % 2) == 0);
                if (wr) begin
                    e.we = 1'b0;
                    e.dqoe = (s >= 1);
                    e.dq = w[4*k +: 4];
                end else begin
                    e.oe = 1'b0;
                    if (s >= 3 && (s % 2) == 1) begin
                        e.rv = 1'b1;
                        e.rd = pat(r, c[8*((s-3)/2) +: 8]);
                    end
                end
            end
            exq.push_back(e);
        end
        e = idle_v();
        if (!rmw && !wr) begin e.rv = 1'b1; e.rd = pat(r, c[8*(nb-1) +: 8]); end
        exq.push_back(e);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            // R10 reset state
            chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R10 strobes in reset",
                {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
            chk(!dram_dq_oe && !rd_valid && !req_ready, "R10 enables in reset",
                {dram_dq_oe, rd_valid, req_ready}, 0);
        end else begin
            exp_t e;
            bit   exp_rdy;
            e = (exq.size() > 0) ? exq.pop_front() : idle_v();
            exp_rdy = (exq.size() == 0) && (cyc >= INIT_CYC);
            chk(dram_ras_n == e.ras, "R2 ras_n", dram_ras_n, e.ras);
            chk(dram_cas_n == e.cas, "R3 cas_n", dram_cas_n, e.cas);
            chk(dram_we_n == e.we, "R5/R6 we_n", dram_we_n, e.we);
            chk(dram_oe_n == e.oe, "R4/R6 oe_n", dram_oe_n, e.oe);
            chk(dram_addr == e.addr, "R1 addr", dram_addr, e.addr);
            chk(dram_dq_oe == e.dqoe, "R8 dq_oe", dram_dq_oe, e.dqoe);
            if (e.dqoe) chk(dram_dq_o == e.dq, "R5/R7 dq_o", dram_dq_o, e.dq);
            chk(rd_valid == e.rv, "R4/R7 rd_valid", rd_valid, e.rv);
            if (e.rv) chk(rd_data == e.rd, "R4/R7 rd_data", rd_data, e.rd);
            chk(req_ready == exp_rdy, "R9/R10 req_ready", req_ready, exp_rdy);
            if (req_valid && req_ready)
                plan(req_kind, req_row, req_cols, req_beats, req_wdata, req_op);
            cyc++;
        end
    end

    // called just after a rising edge; returns just after the accepting edge
    task automatic send(input logic [1:0] k, input logic [7:0] r, input logic [31:0] c,
                        input logic [2:0] b, input logic [15:0] w, input logic [1:0] op);
        req_kind = k; req_row = r; req_cols = c; req_beats = b;
        req_wdata = w; req_op = op; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: ready held low for INIT_CYC cycles (checked each cycle)
        // R3, R2: single-beat page read, minimum RAS width
        send(2'd0, 8'h12, 32'h0000_0047, 3'd1, 16'h0, 2'd0);
        // R4, R1: four-column read with a scattered list; next request overlaps precharge
        send(2'd0, 8'h34, 32'hF0_81_3C_05, 3'd4, 16'h0, 2'd0);
        send(2'd0, 8'hA5, 32'h00_00_77_E2, 3'd2, 16'h0, 2'd0);
        repeat (3) @(posedge clk); #1;
        // R5: three-beat page write
        send(2'd1, 8'h56, 32'h00_19_2B_C0, 3'd3, 16'h0A5C, 2'd0);
        // R6, R7: read-modify-write, every operation, issued back to back
        send(2'd2, 8'h78, 32'h0000_009A, 3'd1, 16'h0006, 2'd0);
        send(2'd2, 8'h79, 32'h0000_0013, 3'd1, 16'h0009, 2'd1);
        send(2'd2, 8'h7A, 32'h0000_00EE, 3'd1, 16'h0003, 2'd2);
        send(2'd2, 8'h7B, 32'h0000_0051, 3'd1, 16'h000D, 2'd3);
        // R9: kind code 3 reads; beats 0 means one beat; beats 7 limited to four
        send(2'd3, 8'hC3, 32'h0000_0028, 3'd0, 16'h0, 2'd0);
        send(2'd1, 8'hC4, 32'h0000_0061, 3'd0, 16'h000B, 2'd0);
        send(2'd0, 8'hD7, 32'h44_33_22_11, 3'd7, 16'h0, 2'd0);
        // R2: write followed at once by a read, 2-cycle precharge
        send(2'd1, 8'h0F, 32'h0B_0A_09_08, 3'd4, 16'h1234, 2'd0);
        send(2'd0, 8'h10, 32'h0000_00FF, 3'd1, 16'h0, 2'd0);
        while (exq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule